// File: doc/BRIEF.md
# Exception entry and return sequencer

This block is the trap-control unit of a small 32-bit core. Each cycle it looks at seven exception request lines, the current program counter and the current status word. It also looks at a return request. When a request is accepted, the block performs the whole entry in one clock edge. It banks the status word and a return address for the target mode, builds the new status word with the correct mode and interrupt masks, and sends the program counter to a fixed vector.

A return request restores the status word and the program counter from the bank of the current mode, again in one step. The core feeds `psr_out` and `pc_out` back as its live state whenever `upd_vld` pulses. The saved-status and link registers for the five privileged trapping modes live inside the block. They become visible through the values a return produces.

Top module: `trap_sequencer`

## Requirements
- R1: After `rst_n` is released, `upd_vld` is 0, `pc_out` is 0 and `psr_out` is 32'h0000_00D3 (Supervisor, both masks set). Every banked saved-status and link register holds 0.
- R2: An accepted exception loads `pc_out` with its vector. The vectors are: data abort 0x10, FIQ 0x1C, IRQ 0x18, prefetch abort 0x0C, undefined 0x04, software interrupt 0x08 and reset request 0x00. `upd_vld` is 1 in the cycle after the request is sampled.
- R3: The mode field is `psr_out[4:0]`. It is encoded as User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. The target mode is Abort for both aborts, Undefined for an undefined instruction, Supervisor for a software interrupt or a reset request, IRQ for IRQ and FIQ for FIQ.
- R4: On entry other than reset, bit 7 (I) is set. Bit 6 (F) is also set for FIQ and is otherwise copied. Bits 31:8 and bit 5 are copied from `cur_psr`.
- R5: On entry other than reset, the target mode's saved status receives `cur_psr` unchanged, and its link register receives `cur_pc - 4`, modulo 2^32.
- R6: Only one request is taken per cycle. The priority runs from highest to lowest: reset request, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R7: IRQ is ignored while `cur_psr[7]` is 1, and FIQ is ignored while `cur_psr[6]` is 1. A lower-priority request is taken in their place.
- R8: A return in a banked mode sets `psr_out` to that mode's saved status. It sets `pc_out` to the link value, or to the link value minus 4 when `ret_extra` is 1.
- R9: A return in User or System mode, or in any unlisted mode code, has no effect. `upd_vld` stays 0 and `pc_out` and `psr_out` keep their values.
- R10: A reset request gives `pc_out` 0 and `psr_out` 32'h0000_00D3. It writes neither the Supervisor saved status nor the Supervisor link register.
- R11: An exception wins over a return sampled in the same cycle. In any cycle where nothing is taken, `upd_vld` is 0 and both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_rst | input | 1 | Reset request |
| rq_undef | input | 1 | Undefined instruction |
| rq_swi | input | 1 | Software interrupt |
| rq_pabt | input | 1 | Prefetch abort |
| rq_dabt | input | 1 | Data abort |
| rq_irq | input | 1 | Normal interrupt |
| rq_fiq | input | 1 | Fast interrupt |
| ret_req | input | 1 | Return from handler |
| ret_extra | input | 1 | Subtract a further 4 on return |
| cur_pc | input | XLEN | Current program counter |
| cur_psr | input | 32 | Current status word |
| upd_vld | output | 1 | New PC and status issued |
| pc_out | output | XLEN | Redirected program counter |
| psr_out | output | 32 | New status word |

## Verification
The bench uses the default parameters: XLEN of 32 and a return step of 4. Under these values the link arithmetic wraps at address zero, and a directed case drives that wrap.

The full 32-bit status word is randomised, with the mode field drawn from all seven legal codes and some illegal ones. This brings every mask combination within reach. It also covers nested entries that overwrite one bank while another bank keeps its contents, and returns that reach banks written many cycles earlier.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int PSR_W  = 32;
  localparam int NBANK  = 5;
  localparam int BANK_W = $clog2(NBANK);
  localparam int BIT_I  = 7;
  localparam int BIT_F  = 6;

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;

  localparam logic [PSR_W-1:0] PSR_RST = {24'h0, 1'b1, 1'b1, 1'b0, MD_SVC};

  typedef enum logic [2:0] {
    TK_NONE, TK_RST, TK_DABT, TK_FIQ, TK_IRQ, TK_PABT, TK_UND, TK_SWI
  } trap_kind_e;

  typedef struct packed {
    logic              hit;
    logic [BANK_W-1:0] idx;
  } bank_sel_t;

  function automatic logic [4:0] kind_mode(trap_kind_e k);
    case (k)
      TK_DABT, TK_PABT: return MD_ABT;
      TK_FIQ:           return MD_FIQ;
      TK_IRQ:           return MD_IRQ;
      TK_UND:           return MD_UND;
      default:          return MD_SVC;
    endcase
  endfunction

  function automatic logic [7:0] kind_vec(trap_kind_e k);
    case (k)
      TK_UND:  return 8'h04;
      TK_SWI:  return 8'h08;
      TK_PABT: return 8'h0C;
      TK_DABT: return 8'h10;
      TK_IRQ:  return 8'h18;
      TK_FIQ:  return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bank_sel_t mode_bank(logic [4:0] m);
    bank_sel_t s;
    s.hit = 1'b1;
    case (m)
      MD_FIQ:  s.idx = BANK_W'(0);
      MD_IRQ:  s.idx = BANK_W'(1);
      MD_SVC:  s.idx = BANK_W'(2);
      MD_ABT:  s.idx = BANK_W'(3);
      MD_UND:  s.idx = BANK_W'(4);
      default: begin s.hit = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic       rq_rst,
  input  logic       rq_undef,
  input  logic       rq_swi,
  input  logic       rq_pabt,
  input  logic       rq_dabt,
  input  logic       rq_irq,
  input  logic       rq_fiq,
  input  logic       mask_i,
  input  logic       mask_f,
  output trap_kind_e kind
);
  always_comb begin
    if (rq_rst)                 kind = TK_RST;
    else if (rq_dabt)           kind = TK_DABT;
    else if (rq_fiq && !mask_f) kind = TK_FIQ;
    else if (rq_irq && !mask_i) kind = TK_IRQ;
    else if (rq_pabt)           kind = TK_PABT;
    else if (rq_undef)          kind = TK_UND;
    else if (rq_swi)            kind = TK_SWI;
    else                        kind = TK_NONE;
  end
endmodule

// File: rtl/trap_bank.sv
module trap_bank #(
  parameter int XLEN  = 32,
  parameter int PSR_W = 32,
  parameter int NBANK = 5,
  localparam int IW   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [PSR_W-1:0] wpsr,
  input  logic [XLEN-1:0]  wlr,
  input  logic [IW-1:0]    ridx,
  output logic [PSR_W-1:0] rpsr,
  output logic [XLEN-1:0]  rlr
);
  logic [PSR_W-1:0] psr_q [NBANK];
  logic [XLEN-1:0]  lr_q  [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_slot
    logic hit;
    assign hit = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        psr_q[g] <= '0;
        lr_q[g]  <= '0;
      end else if (hit) begin
        psr_q[g] <= wpsr;
        lr_q[g]  <= wlr;
      end
    end
  end

  always_comb begin
    rpsr = '0;
    rlr  = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (ridx == IW'(i)) begin
        rpsr = psr_q[i];
        rlr  = lr_q[i];
      end
    end
  end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int RET_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rq_rst,
  input  logic             rq_undef,
  input  logic             rq_swi,
  input  logic             rq_pabt,
  input  logic             rq_dabt,
  input  logic             rq_irq,
  input  logic             rq_fiq,
  input  logic             ret_req,
  input  logic             ret_extra,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [PSR_W-1:0] cur_psr,
  output logic             upd_vld,
  output logic [XLEN-1:0]  pc_out,
  output logic [PSR_W-1:0] psr_out
);
  localparam logic [XLEN-1:0] STEP = XLEN'(RET_STEP);

  trap_kind_e       kind;
  bank_sel_t        tsel, csel;
  logic [4:0]       tgt_mode;
  logic             bk_we;
  logic [BANK_W-1:0] bk_widx;
  logic [PSR_W-1:0] bk_rpsr;
  logic [XLEN-1:0]  bk_rlr;
  logic             vld_q, nxt_vld;
  logic [XLEN-1:0]  pc_q, nxt_pc;
  logic [PSR_W-1:0] psr_q, nxt_psr;

  trap_arbiter u_arb (
    .rq_rst  (rq_rst),
    .rq_undef(rq_undef),
    .rq_swi  (rq_swi),
    .rq_pabt (rq_pabt),
    .rq_dabt (rq_dabt),
    .rq_irq  (rq_irq),
    .rq_fiq  (rq_fiq),
    .mask_i  (cur_psr[BIT_I]),
    .mask_f  (cur_psr[BIT_F]),
    .kind    (kind)
  );

  assign tgt_mode = kind_mode(kind);
  assign tsel     = mode_bank(tgt_mode);
  assign csel     = mode_bank(cur_psr[4:0]);

  trap_bank #(.XLEN(XLEN), .PSR_W(PSR_W), .NBANK(NBANK)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (bk_we),
    .widx (bk_widx),
    .wpsr (cur_psr),
    .wlr  (cur_pc - STEP),
    .ridx (csel.idx),
    .rpsr (bk_rpsr),
    .rlr  (bk_rlr)
  );

  // next-state: entry beats return; otherwise hold
  always_comb begin
    nxt_vld = 1'b0;
    nxt_pc  = pc_q;
    nxt_psr = psr_q;
    bk_we   = 1'b0;
    bk_widx = tsel.idx;
    if (kind == TK_RST) begin
      nxt_vld = 1'b1;
      nxt_pc  = '0;
      nxt_psr = PSR_RST;
    end else if (kind != TK_NONE) begin
      nxt_vld        = 1'b1;
      nxt_pc         = XLEN'(kind_vec(kind));
      nxt_psr        = cur_psr;
      nxt_psr[4:0]   = tgt_mode;
      nxt_psr[BIT_I] = 1'b1;
      if (kind == TK_FIQ) nxt_psr[BIT_F] = 1'b1;
      bk_we          = tsel.hit;
    end else if (ret_req && csel.hit) begin
      nxt_vld = 1'b1;
      nxt_pc  = bk_rlr - (ret_extra ? STEP : '0);
      nxt_psr = bk_rpsr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pc_q  <= '0;
      psr_q <= PSR_RST;
    end else begin
      vld_q <= nxt_vld;
      if (nxt_vld) begin
        pc_q  <= nxt_pc;
        psr_q <= nxt_psr;
      end
    end
  end

  assign upd_vld = vld_q;
  assign pc_out  = pc_q;
  assign psr_out = psr_q;
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rq_rst,
  input logic             rq_undef,
  input logic             rq_swi,
  input logic             rq_pabt,
  input logic             rq_dabt,
  input logic             rq_irq,
  input logic             rq_fiq,
  input logic             ret_req,
  input logic [4:0]       cur_mode,
  input logic             cur_i,
  input logic             cur_f,
  input logic             upd_vld,
  input logic [XLEN-1:0]  pc_out,
  input logic [PSR_W-1:0] psr_out
);
  logic any_rq;
  assign any_rq = rq_rst | rq_undef | rq_swi | rq_pabt | rq_dabt | rq_irq | rq_fiq;

  p_reset_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rq_rst |=> upd_vld && pc_out == '0 && psr_out == PSR_RST);

  p_dabt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_dabt && !rq_rst) |=> upd_vld && pc_out == XLEN'(16) &&
                             psr_out[4:0] == MD_ABT && psr_out[BIT_I]);

  p_fiq_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_fiq && !cur_f && !rq_rst && !rq_dabt) |=> upd_vld && psr_out[BIT_F] &&
      psr_out[BIT_I] && psr_out[4:0] == MD_FIQ && pc_out == XLEN'(28));

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_irq && cur_i && !rq_rst && !rq_undef && !rq_swi && !rq_pabt &&
     !rq_dabt && !rq_fiq && !ret_req) |=> !upd_vld);

  p_unbanked_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !any_rq && (cur_mode == MD_USR || cur_mode == MD_SYS)) |=> !upd_vld);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_rq && !ret_req) |=> !upd_vld && $stable(pc_out) && $stable(psr_out));

  p_swi_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_swi && !rq_rst && !rq_dabt && !rq_pabt && !rq_undef &&
     !(rq_fiq && !cur_f) && !(rq_irq && !cur_i)) |=> psr_out[4:0] == MD_SVC &&
                                                      pc_out == XLEN'(8));
endmodule

bind trap_sequencer trap_sequencer_chk #(.XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rq_rst  (rq_rst),
  .rq_undef(rq_undef),
  .rq_swi  (rq_swi),
  .rq_pabt (rq_pabt),
  .rq_dabt (rq_dabt),
  .rq_irq  (rq_irq),
  .rq_fiq  (rq_fiq),
  .ret_req (ret_req),
  .cur_mode(cur_psr[4:0]),
  .cur_i   (cur_psr[7]),
  .cur_f   (cur_psr[6]),
  .upd_vld (upd_vld),
  .pc_out  (pc_out),
  .psr_out (psr_out)
);

// File: tb/trap_sequencer_test.sv
module trap_sequencer_test;
  localparam int CLK_NS = 10;
  localparam logic [4:0] U_M = 5'b10000, F_M = 5'b10001, I_M = 5'b10010,
                         S_M = 5'b10011, A_M = 5'b10111, N_M = 5'b11011, Y_M = 5'b11111;
  localparam logic [31:0] RST_PSR = 32'h0000_00D3;

  logic clk = 1'b0;
  logic rst_n;
  logic rq_rst, rq_undef, rq_swi, rq_pabt, rq_dabt, rq_irq, rq_fiq, ret_req, ret_extra;
  logic [31:0] cur_pc, cur_psr;
  logic upd_vld;
  logic [31:0] pc_out, psr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] m_spsr [5];
  logic [31:0] m_lr   [5];
  logic        e_vld;
  logic [31:0] e_pc, e_psr;

  always #(CLK_NS/2) clk = ~clk;

  trap_sequencer uut (
    .clk(clk), .rst_n(rst_n), .rq_rst(rq_rst), .rq_undef(rq_undef), .rq_swi(rq_swi),
    .rq_pabt(rq_pabt), .rq_dabt(rq_dabt), .rq_irq(rq_irq), .rq_fiq(rq_fiq),
    .ret_req(ret_req), .ret_extra(ret_extra), .cur_pc(cur_pc), .cur_psr(cur_psr),
    .upd_vld(upd_vld), .pc_out(pc_out), .psr_out(psr_out)
  );

  function automatic int pick(bit r, bit u, bit s, bit p, bit d, bit i, bit f,
                              logic [31:0] psr);
    if (r) return 1;
    if (d) return 2;
    if (f && !psr[6]) return 3;
    if (i && !psr[7]) return 4;
    if (p) return 5;
    if (u) return 6;
    if (s) return 7;
    return 0;
  endfunction

  function automatic logic [31:0] vec_of(int k);
    case (k)
      2: return 32'h10;
      3: return 32'h1C;
      4: return 32'h18;
      5: return 32'h0C;
      6: return 32'h04;
      7: return 32'h08;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(int k);
    case (k)
      2, 5: return A_M;
      3:    return F_M;
      4:    return I_M;
      6:    return N_M;
      default: return S_M;
    endcase
  endfunction

  function automatic int slot_of(logic [4:0] m);
    case (m)
      F_M: return 0;
      I_M: return 1;
      S_M: return 2;
      A_M: return 3;
      N_M: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit u, bit s, bit p, bit d, bit i, bit f, bit rt, bit ad,
                      logic [31:0] pc, logic [31:0] psr, string tag);
    int k;
    int sl;
    rq_rst = r; rq_undef = u; rq_swi = s; rq_pabt = p; rq_dabt = d;
    rq_irq = i; rq_fiq = f; ret_req = rt; ret_extra = ad;
    cur_pc = pc; cur_psr = psr;
    k = pick(r, u, s, p, d, i, f, psr);
    if (k == 1) begin
      e_vld = 1'b1; e_pc = 32'h0; e_psr = RST_PSR;
    end else if (k != 0) begin
      e_vld = 1'b1;
      e_pc  = vec_of(k);
      e_psr = psr;
      e_psr[4:0] = mode_of(k);
      e_psr[7] = 1'b1;
      if (k == 3) e_psr[6] = 1'b1;
      sl = slot_of(mode_of(k));
      m_spsr[sl] = psr;
      m_lr[sl]   = pc - 32'd4;
    end else begin
      sl = slot_of(psr[4:0]);
      if (rt && sl >= 0) begin
        e_vld = 1'b1;
        e_pc  = m_lr[sl] - (ad ? 32'd4 : 32'd0);
        e_psr = m_spsr[sl];
      end else begin
        e_vld = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " upd_vld"}, {31'b0, upd_vld}, {31'b0, e_vld});
    chk({tag, " pc_out"}, pc_out, e_pc);
    chk({tag, " psr_out"}, psr_out, e_psr);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [8];
    logic [31:0] rp, rs, pv;
    string tg;
    int k;
    modes = '{U_M, F_M, I_M, S_M, A_M, N_M, Y_M, 5'b00101};
    void'($urandom(32'd4711));
    for (int j = 0; j < 5; j++) begin m_spsr[j] = '0; m_lr[j] = '0; end
    e_vld = 1'b0; e_pc = '0; e_psr = RST_PSR;
    rst_n = 1'b0;
    {rq_rst, rq_undef, rq_swi, rq_pabt, rq_dabt, rq_irq, rq_fiq, ret_req, ret_extra} = '0;
    cur_pc = '0; cur_psr = 32'h10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and cleared banks
    chk("R1 reset upd_vld", {31'b0, upd_vld}, 32'd0);
    chk("R1 reset pc_out", pc_out, 32'd0);
    chk("R1 reset psr_out", psr_out, RST_PSR);
    step(0,0,0,0,0,0,0,1,0, 32'h40, {27'h6, S_M}, "R1 cleared bank return");

    // R2 R3 R4: software interrupt from User, T and flags kept
    step(0,0,1,0,0,0,0,0,0, 32'h1000, 32'h6000_0030, "R2 R3 R4 swi entry");
    chk("R4 swi psr exact", psr_out, 32'h6000_00B3);
    // R5 R8: return from Supervisor
    step(0,0,0,0,0,0,0,1,0, 32'h8, 32'h6000_00B3, "R5 R8 swi return");
    chk("R8 return pc exact", pc_out, 32'h0000_0FFC);

    // nested: IRQ from User, then FIQ inside IRQ handler
    step(0,0,0,0,0,1,0,0,0, 32'h2000, 32'h8000_0010, "R2 R3 irq entry");
    step(0,0,0,0,0,0,1,0,0, 32'h0300, 32'h8000_0092, "R3 R4 fiq nested");
    chk("R4 fiq sets F", psr_out, 32'h8000_00D1);
    step(0,0,0,0,0,0,0,1,1, 32'h0020, 32'h8000_00D1, "R8 fiq return extra");
    step(0,0,0,0,0,0,0,1,0, 32'h0304, 32'h8000_0092, "R5 R8 irq return");

    // R7: masking
    step(0,0,0,0,0,1,0,0,0, 32'h3000, 32'h0000_0090, "R7 irq masked");
    step(0,0,0,1,0,0,1,0,0, 32'h3004, 32'h0000_0050, "R6 R7 fiq masked pabt wins");

    // R6: priority ladder, masks clear
    step(1,1,1,1,1,1,1,1,0, 32'h5000, 32'h0000_0010, "R6 all reset wins");
    step(0,1,1,1,1,1,1,0,0, 32'h5000, 32'h0000_0010, "R6 dabt wins");
    step(0,1,1,1,0,1,1,0,0, 32'h5100, 32'h0000_0010, "R6 fiq wins");
    step(0,1,1,1,0,1,0,0,0, 32'h5200, 32'h0000_0010, "R6 irq wins");
    step(0,1,1,1,0,0,0,0,0, 32'h5300, 32'h0000_0010, "R6 pabt wins");
    step(0,1,1,0,0,0,0,0,0, 32'h5400, 32'h0000_0010, "R6 undef wins");

    // R10: reset request keeps Supervisor bank
    step(0,0,1,0,0,0,0,0,0, 32'h7000, 32'h2000_0010, "R10 swi before reset");
    step(1,0,0,0,0,0,0,0,0, 32'h0008, 32'h2000_0093, "R10 reset request");
    step(0,0,0,0,0,0,0,1,0, 32'h0000, RST_PSR, "R10 svc bank kept");
    chk("R10 restored psr", psr_out, 32'h2000_0010);
    chk("R10 restored pc", pc_out, 32'h6FFC);

    // R9: returns without a bank
    step(0,0,0,0,0,0,0,1,0, 32'h10, 32'h0000_0010, "R9 user return");
    step(0,0,0,0,0,0,0,1,1, 32'h10, 32'h0000_001F, "R9 system return");
    step(0,0,0,0,0,0,0,1,0, 32'h10, 32'h0000_0005, "R9 bad mode return");

    // R11: exception beats return; R5: link wraps
    step(0,1,0,0,0,0,0,1,0, 32'h9000, 32'h0000_0017, "R11 undef beats return");
    step(0,0,0,0,1,0,0,0,0, 32'h0, 32'h0000_0010, "R5 dabt at pc 0");
    step(0,0,0,0,0,0,0,1,0, 32'h10, 32'h0000_0097, "R5 wrapped link");
    chk("R5 wrap exact", pc_out, 32'hFFFF_FFFC);
    step(0,0,0,0,0,0,0,0,0, 32'h44, 32'h0000_0097, "R11 idle hold");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit r, u, s, p, d, i, f, rt, ad;
      r  = ($urandom % 64) == 0;
      u  = ($urandom % 8) == 0;
      s  = ($urandom % 8) == 0;
      p  = ($urandom % 10) == 0;
      d  = ($urandom % 12) == 0;
      i  = ($urandom % 5) == 0;
      f  = ($urandom % 6) == 0;
      rt = ($urandom % 3) == 0;
      ad = $urandom % 2;
      rp = $urandom;
      rs = $urandom;
      rs[4:0] = modes[$urandom % 8];
      pv = rp;
      k = pick(r, u, s, p, d, i, f, rs);
      case (k)
        0: tg = rt ? "R8 R9 R11 random return" : "R11 random idle";
        1: tg = "R10 random reset";
        default: tg = "R2 R3 R4 R5 R6 R7 random entry";
      endcase
      step(r, u, s, p, d, i, f, rt, ad, pv, rs, tg);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule